// File: doc/BRIEF.md
# Sliding-Window Branch-Metric Store for a Windowed MAP Decoder

This block holds the branch metrics of a windowed soft-in soft-out MAP decoder and hands them out to three recursion units. Metrics arrive one per trellis step. The block returns three read streams. The forward recursion receives the metrics in their arrival order, delayed by two windows. Two backward recursion units receive the metrics in reversed order. The backward units take turns: one spends a window on training, whose results are thrown away, while the other produces state metrics that are kept.

Storage is three sections of L entries each, and the sections are used in rotation. At any step, one section is being refilled with new metrics. In the same step, the keeping backward unit pops the old contents of that section, and the entry it pops is the one that is overwritten. The section written before that is popped by the training unit. The section written before that one is read forward. Each section has one direction bit that flips every time the section is refilled, so every read address is either the step position or its mirror. No address arithmetic beyond that is needed.

A frame ends with a flagged last word. The block then refuses input, pads out the partial window and runs the schedule on empty entries until the last real window has been kept. After that it starts the next frame from a clean state. Every output word carries a valid flag, which is high only for real frame data. Each backward output also carries a keep flag.

Top module: `bm_window_buffer`

## Requirements
- R1: After reset `fw_valid`, `bk0_valid` and `bk1_valid` are low and `bm_ready` is high.
- R2: A step happens in every cycle where `bm_valid` and `bm_ready` are both high, and in every cycle where `bm_ready` is low. The outputs for a step are registered and appear in the next cycle. In the cycle after a cycle with no step, all three valid outputs are low.
- R3: Steps are numbered s = 0, 1, ... from the start of a frame, with block k = s / L and position t = s mod L. At step s the forward port carries frame word (k-2)·L + t. The forward stream is therefore the input in its own order, delayed by 2L steps.
- R4: At step s, backward unit number (k mod 2) carries frame word (k-1)·L + (L-1-t) with `keep` low. This is the training pass over the block just completed, in reverse order.
- R5: At step s, the other backward unit, number ((k+1) mod 2), carries frame word (k-3)·L + (L-1-t) with `keep` high. This word comes from the section that is being refilled in the same step, and it is the value held there before that step's write.
- R6: Any read whose frame index is negative or at least the frame length N has its valid output low. This covers the start of a frame and the padding of a partial last block.
- R7: Suppose a step accepts a word with `bm_last` high at position t. Then `bm_ready` is low from the next cycle for exactly (L-1-t) + 3·L cycles. After that it goes high again, and the step numbering restarts at 0 for the next frame.
- R8: While `bm_ready` is low, `bm_valid`, `bm_last` and `bm_data` have no effect. The step sequence and every output word of the drain are the same as they would be with the inputs idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bm_valid | input | 1 | Branch-metric word present |
| bm_last | input | 1 | Word is the last of its frame |
| bm_data | input | W | Branch-metric word |
| bm_ready | output | 1 | Low while the block drains a finished frame |
| fw_valid | output | 1 | Forward word holds frame data |
| fw_metric | output | W | Word for the forward recursion |
| bk0_valid | output | 1 | Backward unit 0 word holds frame data |
| bk0_keep | output | 1 | Backward unit 0 is in its kept half |
| bk0_metric | output | W | Word for backward unit 0 |
| bk1_valid | output | 1 | Backward unit 1 word holds frame data |
| bk1_keep | output | 1 | Backward unit 1 is in its kept half |
| bk1_metric | output | W | Word for backward unit 1 |

## Verification
The hardest case to reach is the keeping pop at a frame's tail. There, the section being refilled with padding still owes its last real block to a backward unit, and this happens after a partial block whose padding must never show as valid. The stimulus produces it with frames of length 1, of lengths that are not multiples of L, and of lengths that are exact multiples of L. Random input gaps make the step positions irregular. During every drain the bench drives random valid, last and data values, so any leak of ignored input would change an output word.

// File: rtl/bm_window_buffer.sv
module bm_window_buffer #(
  parameter int WIN = 8,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bm_valid,
  input  logic         bm_last,
  input  logic [W-1:0] bm_data,
  output logic         bm_ready,
  output logic         fw_valid,
  output logic [W-1:0] fw_metric,
  output logic         bk0_valid,
  output logic         bk0_keep,
  output logic [W-1:0] bk0_metric,
  output logic         bk1_valid,
  output logic         bk1_keep,
  output logic [W-1:0] bk1_metric
);

  localparam int TW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [TW-1:0] TLAST = TW'(WIN - 1);

  logic [W-1:0] mem    [3][WIN];
  logic         live_q [3][WIN];
  logic [2:0]   dir_q;
  logic [TW-1:0] t_q;
  logic [1:0]   sec_q, cnt_q;
  logic         par_q, drain_q;

  function automatic logic [TW-1:0] pick(input logic d, input logic [TW-1:0] t);
    return d ? (TLAST - t) : t;
  endfunction

  logic step, take_last, wrap, fin;
  logic [1:0] trs, fws, cnt_base;
  logic [TW-1:0] wa, tra, fwa;
  logic tr_v, kp_v, fw_v;
  logic [W-1:0] tr_d, kp_d, fw_d;

  assign bm_ready  = !drain_q;
  assign step      = drain_q | bm_valid;
  assign take_last = bm_valid & bm_last & !drain_q;
  assign wrap      = (t_q == TLAST);
  assign cnt_base  = take_last ? 2'd3 : cnt_q;
  assign fin       = wrap & drain_q & (cnt_base == 2'd0);

  assign trs = (sec_q == 2'd0) ? 2'd2 : sec_q - 2'd1;
  assign fws = (sec_q == 2'd2) ? 2'd0 : sec_q + 2'd1;
  assign wa  = pick(dir_q[sec_q], t_q);
  assign tra = pick(dir_q[trs], t_q);
  assign fwa = pick(!dir_q[fws], t_q);

  assign kp_v = live_q[sec_q][wa];
  assign kp_d = mem[sec_q][wa];
  assign tr_v = live_q[trs][tra];
  assign tr_d = mem[trs][tra];
  assign fw_v = live_q[fws][fwa];
  assign fw_d = mem[fws][fwa];

  always_ff @(posedge clk) begin
    if (step) mem[sec_q][wa] <= drain_q ? '0 : bm_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < WIN; j++)
          live_q[i][j] <= 1'b0;
      dir_q      <= '0;
      t_q        <= '0;
      sec_q      <= '0;
      cnt_q      <= '0;
      par_q      <= 1'b0;
      drain_q    <= 1'b0;
      fw_valid   <= 1'b0;
      fw_metric  <= '0;
      bk0_valid  <= 1'b0;
      bk0_keep   <= 1'b0;
      bk0_metric <= '0;
      bk1_valid  <= 1'b0;
      bk1_keep   <= 1'b0;
      bk1_metric <= '0;
    end else begin
      fw_valid   <= step & fw_v;
      fw_metric  <= fw_d;
      bk0_valid  <= step & (par_q ? kp_v : tr_v);
      bk0_keep   <= par_q;
      bk0_metric <= par_q ? kp_d : tr_d;
      bk1_valid  <= step & (par_q ? tr_v : kp_v);
      bk1_keep   <= !par_q;
      bk1_metric <= par_q ? tr_d : kp_d;
      if (step) begin
        live_q[sec_q][wa] <= !drain_q;
        if (take_last) drain_q <= 1'b1;
        if (wrap) begin
          dir_q[sec_q] <= ~dir_q[sec_q];
          t_q <= '0;
          if (fin) begin
            sec_q   <= '0;
            par_q   <= 1'b0;
            drain_q <= 1'b0;
            cnt_q   <= '0;
          end else begin
            sec_q <= (sec_q == 2'd2) ? 2'd0 : sec_q + 2'd1;
            par_q <= ~par_q;
            if (drain_q | take_last) cnt_q <= cnt_base - 2'd1;
          end
        end else begin
          t_q <= t_q + 1'b1;
          if (take_last) cnt_q <= 2'd3;
        end
      end
    end
  end

  a_r2_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_ready && !bm_valid) |=> (!fw_valid && !bk0_valid && !bk1_valid));

  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_valid && bm_ready && bm_last) |=> !bm_ready);

  a_r7_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bm_ready) |-> $past(bm_valid && bm_last));

  a_r6_fw_quiet_at_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bm_ready) |-> !fw_valid);

  a_r4_no_training_at_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bm_ready) |-> (!(bk0_valid && !bk0_keep) && !(bk1_valid && !bk1_keep)));

endmodule

// File: tb/sim_bm_window_buffer.sv
module sim_bm_window_buffer;
  localparam int WIN = 8;
  localparam int W   = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic bm_valid, bm_last;
  logic [W-1:0] bm_data;
  logic bm_ready, fw_valid, bk0_valid, bk0_keep, bk1_valid, bk1_keep;
  logic [W-1:0] fw_metric, bk0_metric, bk1_metric;

  always #2 clk = ~clk;

  bm_window_buffer #(.WIN(WIN), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bm_valid(bm_valid), .bm_last(bm_last),
    .bm_data(bm_data), .bm_ready(bm_ready),
    .fw_valid(fw_valid), .fw_metric(fw_metric),
    .bk0_valid(bk0_valid), .bk0_keep(bk0_keep), .bk0_metric(bk0_metric),
    .bk1_valid(bk1_valid), .bk1_keep(bk1_keep), .bk1_metric(bk1_metric)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] words [0:63];
  bit           p_any, p_drain, p_fv;
  logic [W-1:0] p_fd;
  bit           p_bv [2];
  bit           p_bk [2];
  logic [W-1:0] p_bd [2];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compute_exp(input int s, input int n);
    int k, t, idx, u;
    k = s / WIN;
    t = s % WIN;
    p_any   = 1'b1;
    p_drain = (s >= n);
    idx  = (k - 2) * WIN + t;
    p_fv = (k >= 2) && (idx < n);
    p_fd = p_fv ? words[idx] : '0;
    u = k % 2;
    idx = (k - 1) * WIN + (WIN - 1 - t);
    p_bv[u] = (k >= 1) && (idx < n);
    p_bk[u] = 1'b0;
    p_bd[u] = p_bv[u] ? words[idx] : '0;
    u = (k + 1) % 2;
    idx = (k - 3) * WIN + (WIN - 1 - t);
    p_bv[u] = (k >= 3) && (idx < n);
    p_bk[u] = 1'b1;
    p_bd[u] = p_bv[u] ? words[idx] : '0;
  endtask

  task automatic check_pending();
    string rq;
    if (!p_any) begin
      chk("R2", "fw_valid after no step", fw_valid, 0);
      chk("R2", "bk0_valid after no step", bk0_valid, 0);
      chk("R2", "bk1_valid after no step", bk1_valid, 0);
    end else begin
      rq = p_drain ? "R8" : "R3";
      chk(p_fv ? rq : "R6", "fw_valid", fw_valid, p_fv);
      if (p_fv && fw_valid) chk(rq, "fw_metric", fw_metric, p_fd);
      for (int u = 0; u < 2; u++) begin
        logic av, ak;
        logic [W-1:0] ad;
        av = (u == 0) ? bk0_valid : bk1_valid;
        ak = (u == 0) ? bk0_keep : bk1_keep;
        ad = (u == 0) ? bk0_metric : bk1_metric;
        rq = p_bk[u] ? "R5" : "R4";
        chk(p_bv[u] ? rq : "R6", $sformatf("bk%0d_valid", u), av, p_bv[u]);
        if (p_bv[u] && av) begin
          chk(rq, $sformatf("bk%0d_keep", u), ak, p_bk[u]);
          chk(rq, $sformatf("bk%0d_metric", u), ad, p_bd[u]);
        end
      end
    end
  endtask

  task automatic run_frame(input int n, input int gap);
    int s, tot;
    bit v, stp;
    s   = 0;
    tot = ((n + WIN - 1) / WIN) * WIN + 3 * WIN;
    for (int i = 0; i < n; i++) words[i] = W'($urandom);
    while (s < tot) begin
      @(negedge clk);
      check_pending();
      chk("R7", "bm_ready", bm_ready, (s < n) ? 1 : 0);
      if (s < n) begin
        v = (($urandom % 100) >= gap);
        bm_valid = v;
        bm_data  = words[s];
        bm_last  = (s == n - 1);
        stp = v;
      end else begin
        bm_valid = $urandom % 2;
        bm_data  = W'($urandom);
        bm_last  = $urandom % 2;
        stp = 1'b1;
      end
      if (stp) begin
        compute_exp(s, n);
        s++;
      end else begin
        p_any = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7719));
    rst_n = 1'b0;
    bm_valid = 1'b0;
    bm_last = 1'b0;
    bm_data = '0;
    p_any = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "fw_valid after reset", fw_valid, 0);
    chk("R1", "bk0_valid after reset", bk0_valid, 0);
    chk("R1", "bk1_valid after reset", bk1_valid, 0);
    chk("R1", "bm_ready after reset", bm_ready, 1);
    run_frame(24, 0);
    run_frame(13, 0);
    run_frame(1, 0);
    run_frame(8, 30);
    run_frame(7, 20);
    run_frame(40, 40);
    for (int f = 0; f < 6; f++) run_frame(1 + ($urandom % 48), $urandom % 50);
    run_frame(WIN + 1, 0);
    @(negedge clk);
    check_pending();
    bm_valid = 1'b0;
    bm_last  = 1'b0;
    p_any    = 1'b0;
    @(negedge clk);
    check_pending();
    chk("R7", "bm_ready at end", bm_ready, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule